// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a four-bit counter with two separate count inputs, one that counts up and one that counts down. A free-running system clock samples both inputs through synchronizers. A rising edge on either input moves the count by one, but only while the other input rests high. A build parameter selects decade counting (0 to 9) or full binary counting (0 to 15).

Two overrides act on the outputs at once, without waiting for a system clock edge. The master clear forces zero. The active-low load forces the value on the four jam inputs. The clear wins when both are asserted. An edge that falls under an override is ignored, and the count then needs one system cycle to recover.

Two active-low terminal outputs support cascading. The carry output drops while the count sits at its top value and the up input is low. The borrow output drops while the count is zero and the down input is low. Wiring carry to the next stage's up input and borrow to its down input makes that stage advance when the signal rises again.

Top module: `dcnt_updown`

## Requirements
- R1: While `clr` is high, `q` reads 0 within the same cycle, whatever the count inputs do.
- R2: While `clr` is low and `load_n` is low, `q` follows `jam` within the same cycle. The register keeps that value after the load is released.
- R3: With `clr` and `load_n` both asserted, `q` reads 0.
- R4: A rising edge on `up_clk` while `dn_clk` is high adds one to the count. The new value appears on `q` after the second system clock edge that follows the first edge sampling the new level.
- R5: A rising edge on `dn_clk` while `up_clk` is high subtracts one, with the same latency as R4.
- R6: A rising edge on one count input while the other is low leaves the count unchanged. Rising edges detected on both inputs in the same cycle also leave it unchanged.
- R7: Decade mode wraps from 9 to 0 upward and from 0 to 9 downward. Binary mode wraps between 15 and 0. In decade mode, a loaded value of 10 to 15 counts up in binary steps and wraps from 15 to 0.
- R8: `carry_n` is 0 exactly when `q` equals the top value (9 in decade mode, 15 in binary mode) and `up_clk` is low.
- R9: `borrow_n` is 0 exactly when `q` is 0 and `dn_clk` is low.
- R10: A count edge is ignored if it is detected while `clr` or load is active. It is also ignored if it is detected in the first system cycle after their release.
- R11: Two decade stages, with carry driving the upper stage's up input and borrow driving its down input, count as a two-digit number in both directions, including wrap from 0 to 99.
- R12: A synchronous `rst` sets the count to 0 and treats both count inputs as idle-high, so that no edge is detected when the reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| rst | input | 1 | Synchronous active-high system reset |
| clr | input | 1 | Master clear, active high, acts immediately |
| load_n | input | 1 | Parallel load enable, active low, acts immediately |
| jam | input | 4 | Value placed on the count by the load |
| up_clk | input | 1 | Count-up input; its rising edge counts |
| dn_clk | input | 1 | Count-down input; its rising edge counts |
| q | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal-count-up output |
| borrow_n | output | 1 | Active-low terminal-count-down output |

## Verification
A count edge and the release of an override can land in the same system cycle. The bench provokes this by raising `up_clk` while the load is held, then releasing the load either one or two cycles later. In the first case the edge must count; in the second it must be dropped. A behavioural model that keeps its own history of sampled inputs judges every cycle, and directed checks pin both outcomes to exact values. Simultaneous edges on both count inputs are provoked the same way and must cancel.

// File: rtl/updn_pkg.sv
package updn_pkg;

    localparam int CW = 4;

    typedef enum logic {
        MODE_BIN = 1'b0,
        MODE_BCD = 1'b1
    } cnt_mode_e;

    // Synchronized view of one count input
    typedef struct packed {
        logic rise;
        logic lvl;
    } clk_view_t;

    function automatic logic [CW-1:0] top_of(cnt_mode_e m);
        return (m == MODE_BCD) ? CW'(9) : {CW{1'b1}};
    endfunction

    function automatic logic [CW-1:0] step_up(logic [CW-1:0] v, cnt_mode_e m);
        if (m == MODE_BCD && v == CW'(9)) return '0;
        return CW'(v + 1'b1);
    endfunction

    function automatic logic [CW-1:0] step_dn(logic [CW-1:0] v, cnt_mode_e m);
        if (v == '0) return top_of(m);
        return CW'(v - 1'b1);
    endfunction

endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync
    import updn_pkg::*;
#(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output clk_view_t view
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= {DEPTH{IDLE}};
        else     sh <= {sh[DEPTH-2:0], din};
    end

    always_comb begin
        view.lvl  = sh[STAGES-1];
        view.rise = sh[STAGES-1] & ~sh[STAGES];
    end
endmodule

// File: rtl/updn_core.sv
module updn_core
    import updn_pkg::*;
#(
    parameter cnt_mode_e MODE = MODE_BCD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load_n,
    input  logic [CW-1:0] jam,
    input  clk_view_t     up,
    input  clk_view_t     dn,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] q
);
    logic ovr, hold_r, do_up, do_dn;

    assign ovr   = clr | ~load_n;
    assign do_up = up.rise & dn.lvl;
    assign do_dn = dn.rise & up.lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            hold_r <= 1'b0;
        end else begin
            hold_r <= ovr;
            if (clr)
                cnt_q <= '0;
            else if (!load_n)
                cnt_q <= jam;
            else if (!hold_r) begin
                if (do_up && !do_dn)      cnt_q <= step_up(cnt_q, MODE);
                else if (do_dn && !do_up) cnt_q <= step_dn(cnt_q, MODE);
            end
        end
    end

    // Overrides reach the output without a clock edge
    always_comb begin
        if (clr)          q = '0;
        else if (!load_n) q = jam;
        else              q = cnt_q;
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0);

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load_n) |=> cnt_q == $past(jam));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!ovr && !hold_r && (do_up ^ do_dn)) |=> cnt_q != $past(cnt_q));

    assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (!ovr && !(do_up ^ do_dn)) |=> $stable(cnt_q));

    assert_recover_R10: assert property (@(posedge clk) disable iff (rst)
        (!ovr && hold_r) |=> $stable(cnt_q));

    generate
        if (MODE == MODE_BCD) begin : g_bcd_chk
            assert_decade_R7: assert property (@(posedge clk) disable iff (rst)
                (!ovr && cnt_q <= CW'(9)) |=> cnt_q <= CW'(9));
        end
    endgenerate
endmodule

// File: rtl/updn_term.sv
module updn_term
    import updn_pkg::*;
#(
    parameter cnt_mode_e MODE = MODE_BCD
) (
    input  logic [CW-1:0] q,
    input  logic          up_pin,
    input  logic          dn_pin,
    output logic          carry_n,
    output logic          borrow_n
);
    localparam logic [CW-1:0] TOP = top_of(MODE);

    assign carry_n  = ~((q == TOP) & ~up_pin);
    assign borrow_n = ~((q == '0)  & ~dn_pin);
endmodule

// File: rtl/dcnt_updown.sv
module dcnt_updown
    import updn_pkg::*;
#(
    parameter bit BCD = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load_n,
    input  logic [CW-1:0] jam,
    input  logic          up_clk,
    input  logic          dn_clk,
    output logic [CW-1:0] q,
    output logic          carry_n,
    output logic          borrow_n
);
    localparam cnt_mode_e MODE = BCD ? MODE_BCD : MODE_BIN;

    clk_view_t     up_v, dn_v;
    logic [CW-1:0] cnt_q;

    updn_edge_sync #(.STAGES(2), .IDLE(1'b1)) u_up_sync (
        .clk (clk), .rst (rst), .din (up_clk), .view (up_v)
    );

    updn_edge_sync #(.STAGES(2), .IDLE(1'b1)) u_dn_sync (
        .clk (clk), .rst (rst), .din (dn_clk), .view (dn_v)
    );

    updn_core #(.MODE(MODE)) u_core (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .load_n (load_n),
        .jam    (jam),
        .up     (up_v),
        .dn     (dn_v),
        .cnt_q  (cnt_q),
        .q      (q)
    );

    updn_term #(.MODE(MODE)) u_term (
        .q        (q),
        .up_pin   (up_clk),
        .dn_pin   (dn_clk),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    assert_reset_R12: assert property (@(posedge clk)
        rst |=> cnt_q == '0);
endmodule

// File: tb/tb_dcnt_updown.sv
module tb_dcnt_updown;
    logic       clk = 1'b0;
    logic       rst, clr, load_n, up_clk, dn_clk;
    logic [3:0] jam;
    logic [3:0] q_d, q_b, q_h;
    logic       cy_d, bw_d, cy_b, bw_b, cy_h, bw_h;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dcnt_updown #(.BCD(1'b1)) dut (
        .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .jam(jam),
        .up_clk(up_clk), .dn_clk(dn_clk), .q(q_d), .carry_n(cy_d), .borrow_n(bw_d)
    );

    dcnt_updown #(.BCD(1'b0)) dut_bin (
        .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .jam(jam),
        .up_clk(up_clk), .dn_clk(dn_clk), .q(q_b), .carry_n(cy_b), .borrow_n(bw_b)
    );

    dcnt_updown #(.BCD(1'b1)) dut_hi (
        .clk(clk), .rst(rst), .clr(clr), .load_n(1'b1), .jam(4'd0),
        .up_clk(cy_d), .dn_clk(bw_d), .q(q_h), .carry_n(cy_h), .borrow_n(bw_h)
    );

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural reference: history of sampled inputs, one count per mode
    int m_cnt [2];
    int m_top [2] = '{9, 15};
    bit ua1, ua2, ua3, da1, da2, da3, m_hold;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '{0, 0};
            {ua1, ua2, ua3, da1, da2, da3} = 6'b111111;
            m_hold = 1'b0;
        end else begin
            bit ru, rd, cu, cd;
            ru = ua2 && !ua3;
            rd = da2 && !da3;
            cu = ru && da2;
            cd = rd && ua2;
            for (int i = 0; i < 2; i++) begin
                if (clr) m_cnt[i] = 0;
                else if (!load_n) m_cnt[i] = jam;
                else if (!m_hold && cu && !cd)
                    m_cnt[i] = (i == 0 && m_cnt[i] == 9) ? 0 : (m_cnt[i] + 1) % 16;
                else if (!m_hold && cd && !cu)
                    m_cnt[i] = (m_cnt[i] == 0) ? m_top[i] : m_cnt[i] - 1;
            end
            m_hold = clr || !load_n;
            ua3 = ua2; ua2 = ua1; ua1 = up_clk;
            da3 = da2; da2 = da1; da1 = dn_clk;
        end
    end

    function automatic int shown(int i);
        if (clr) return 0;
        if (!load_n) return jam;
        return m_cnt[i];
    endfunction

    // Cycle-by-cycle comparison, away from both edges
    always @(negedge clk) begin
        if (mon_on) begin
            #2;
            check("R4/R5 model q decade", q_d, shown(0));
            check("R4/R5 model q binary", q_b, shown(1));
            check("R8 model carry decade", cy_d, !(shown(0) == 9 && !up_clk));
            check("R8 model carry binary", cy_b, !(shown(1) == 15 && !up_clk));
            check("R9 model borrow decade", bw_d, !(shown(0) == 0 && !dn_clk));
            check("R9 model borrow binary", bw_b, !(shown(1) == 0 && !dn_clk));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_up(int n);
        for (int k = 0; k < n; k++) begin
            up_clk = 1'b0; tick(4);
            up_clk = 1'b1; tick(5);
        end
    endtask

    task automatic pulse_dn(int n);
        for (int k = 0; k < n; k++) begin
            dn_clk = 1'b0; tick(4);
            dn_clk = 1'b1; tick(5);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; clr = 1'b0; load_n = 1'b1; jam = 4'd0;
        up_clk = 1'b1; dn_clk = 1'b1;
        tick(4);
        rst = 1'b0;
        tick(3);
        check("R12 reset decade", q_d, 0);
        check("R12 reset binary", q_b, 0);
        mon_on = 1'b1;

        // R4: plain up counting
        pulse_up(5);
        check("R4 up by five decade", q_d, 5);
        check("R4 up by five binary", q_b, 5);
        // R7: decade wrap upward
        pulse_up(7);
        check("R7 decade wrap up", q_d, 2);
        check("R4 binary reaches 12", q_b, 12);
        // R5: down counting
        pulse_dn(3);
        check("R5 down decade", q_d, 9);
        check("R5 down binary", q_b, 9);

        // R1 with a count edge under clear (R10)
        clr = 1'b1; #1;
        check("R1 clear immediate", q_d, 0);
        tick(1);
        pulse_up(1);
        clr = 1'b0; tick(6);
        check("R10 edge under clear ignored", q_d, 0);
        // R7: down wrap from zero
        pulse_dn(1);
        check("R7 decade wrap down", q_d, 9);
        check("R7 binary wrap down", q_b, 15);

        // R2 / R3 load and clear priority
        jam = 4'd12; load_n = 1'b0; #1;
        check("R2 load immediate", q_d, 12);
        tick(1);
        jam = 4'd14; #1;
        check("R2 load follows jam", q_d, 14);
        tick(1);
        clr = 1'b1; #1;
        check("R3 clear beats load", q_d, 0);
        tick(1);
        clr = 1'b0; #1;
        check("R2 load after clear", q_d, 14);
        tick(2);
        load_n = 1'b1; tick(3);
        check("R2 held after release", q_d, 14);
        pulse_up(1);
        check("R7 decade out of range step", q_d, 15);
        pulse_up(1);
        check("R7 decade 15 wraps to 0", q_d, 0);
        check("R7 binary 15 wraps to 0", q_b, 0);

        // R6: up edge while down input low
        jam = 4'd6; load_n = 1'b0; tick(1); load_n = 1'b1; tick(3);
        dn_clk = 1'b0; tick(3);
        up_clk = 1'b0; tick(4); up_clk = 1'b1; tick(6);
        check("R6 gated up edge", q_d, 6);
        dn_clk = 1'b1; tick(6);
        check("R5 restored down input counts", q_d, 5);
        // R6: simultaneous edges cancel
        up_clk = 1'b0; dn_clk = 1'b0; tick(4);
        up_clk = 1'b1; dn_clk = 1'b1; tick(6);
        check("R6 simultaneous edges", q_d, 5);

        // R8 / R9 immediate terminal outputs
        jam = 4'd9; load_n = 1'b0; tick(1);
        up_clk = 1'b0; #1;
        check("R8 carry low at 9", cy_d, 0);
        check("R8 binary carry high at 9", cy_b, 1);
        tick(1);
        up_clk = 1'b1; #1;
        check("R8 carry returns high", cy_d, 1);
        tick(1);
        jam = 4'd0; tick(1);
        dn_clk = 1'b0; #1;
        check("R9 borrow low at 0", bw_d, 0);
        tick(1);
        dn_clk = 1'b1; tick(1);

        // R10: edge detected in the cycle after release is dropped
        jam = 4'd3; tick(1);
        up_clk = 1'b0; tick(4);
        up_clk = 1'b1; tick(2);
        load_n = 1'b1; tick(6);
        check("R10 edge at release ignored", q_d, 3);
        // one cycle earlier release: the edge counts
        load_n = 1'b0; tick(2);
        up_clk = 1'b0; tick(4);
        up_clk = 1'b1; tick(1);
        load_n = 1'b1; tick(6);
        check("R10 edge after recovery counts", q_d, 4);

        // R11: two cascaded decade stages
        clr = 1'b1; tick(2); clr = 1'b0; tick(4);
        pulse_up(23);
        tick(6);
        check("R11 cascade 23 low digit", q_d, 3);
        check("R11 cascade 23 high digit", q_h, 2);
        pulse_dn(5);
        tick(6);
        check("R11 cascade 18 low digit", q_d, 8);
        check("R11 cascade 18 high digit", q_h, 1);
        pulse_dn(20);
        tick(6);
        check("R11 cascade wrap low digit", q_d, 8);
        check("R11 cascade wrap high digit", q_h, 9);

        mon_on = 1'b0;
        tick(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule